// File: doc/BRIEF.md
# Programmed-I/O Interval Clock and Watchdog

This block is a real-time clock device on a programmed-I/O command port. Software writes a negative count into the interval register. While the clock runs, the counter moves up by one on every tick. A tick is a fixed number of system clocks. When a tick is due and the counter already holds all ones, the count reaches zero. The block then latches a pending interrupt and reloads the programmed interval. The interrupt request is the pending flag gated by a software mask, and a programmable vector accompanies it.

The same command space holds several other functions:
- a watchdog that software rearms;
- a register that drives the front-panel lights;
- readback of two switch banks, one for switches held up and one for momentary-down switches.

Every command is presented for one clock cycle. It carries a class (control pulse, skip test, input or output), a 4-bit function code and write data. The read data and the skip answer are combinational and valid in the cycle the command is presented. All state changes take effect at the clock edge that ends that cycle.

Top module: `clk_pio_timer`

## Requirements
- R1: After reset, every output is 0: no interrupt request, no skip, zero vector, zero lights, no watchdog timeout, and the interval reads back as 0.
- R2: Output (class 3) function 2 loads both the interval register and the counter with the write data. Input (class 2) function 2 returns the interval register.
- R3: While the clock runs, the counter increments once every TICK_DIV clocks. On a tick where the counter is all ones, the pending flag sets and the counter reloads the interval, so an interval of -N gives an event every N ticks.
- R4: irq_req is high exactly when the pending flag and the mask are both set. Control (class 0) function 13 sets the mask and function 14 clears it.
- R5: Control function 0 starts the clock and clears the pending flag. Function 2 stops it and clears the pending flag. Function 1 only clears the pending flag. An overflow in the same cycle as a clear leaves the flag set.
- R6: A skip test (class 1) answers cmd_skip=1 in these cases:
  - function 0, when irq_req is high;
  - function 2, when irq_req is low;
  - function 5, when the watchdog has timed out.
  All other skip functions and all other classes answer 0.
- R7: Control function 6 clears the timeout flag and restarts the watchdog from zero. WDT_TICKS ticks later the timeout flag sets and the watchdog halts. The flag then stays set until function 6 or a master clear. Control function 7 halts the watchdog without clearing the flag.
- R8: Output function 11 sets irq_vector and output function 15 sets panel_lights. Input functions 14 and 15 return panel_up and panel_down. Any other input function returns 0.
- R9: Control function 15 returns all state to its reset value, including the tick phase.
- R10: While the clock is stopped, the counter holds its value. Restarting resumes the count where it stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_class | input | 2 | 0 control, 1 skip test, 2 input, 3 output |
| cmd_func | input | 4 | Function code |
| cmd_wdata | input | CW | Data for output commands |
| cmd_rdata | output | CW | Data returned by input commands |
| cmd_skip | output | 1 | Skip-test answer |
| panel_up | input | CW | Switches in the up position |
| panel_down | input | CW | Switches held momentarily down |
| panel_lights | output | CW | Front-panel light register |
| irq_req | output | 1 | Masked interval interrupt request |
| irq_vector | output | CW | Programmed interrupt vector |
| wdt_timeout | output | 1 | Watchdog timed-out flag |

## Verification
The bench builds the block with TICK_DIV=4 and WDT_TICKS=10. One watchdog period is then 40 clocks and a short negative interval overflows within a dozen clocks. This lets repeated overflows, reloads, watchdog expiry and collisions between an acknowledge and an overflow all occur within a few thousand cycles. A long run of mixed commands exercises the cases where a command lands on a tick edge. Such cases include a load, a stop or a clear in the same cycle as an overflow.

// File: rtl/clk_pio_pkg.sv
package clk_pio_pkg;

    typedef enum logic [1:0] {
        CLS_CTRL = 2'd0,
        CLS_SKIP = 2'd1,
        CLS_IN   = 2'd2,
        CLS_OUT  = 2'd3
    } io_class_e;

    // control pulses
    localparam logic [3:0] FN_RUN      = 4'd0;
    localparam logic [3:0] FN_ACK      = 4'd1;
    localparam logic [3:0] FN_HALT     = 4'd2;
    localparam logic [3:0] FN_WD_ARM   = 4'd6;
    localparam logic [3:0] FN_WD_STOP  = 4'd7;
    localparam logic [3:0] FN_MASK_ON  = 4'd13;
    localparam logic [3:0] FN_MASK_OFF = 4'd14;
    localparam logic [3:0] FN_CLEAR    = 4'd15;

    // skip tests
    localparam logic [3:0] SK_IRQ      = 4'd0;
    localparam logic [3:0] SK_NO_IRQ   = 4'd2;
    localparam logic [3:0] SK_WD_OUT   = 4'd5;

    // data transfers
    localparam logic [3:0] IO_INTERVAL = 4'd2;
    localparam logic [3:0] IO_VECTOR   = 4'd11;
    localparam logic [3:0] IO_SW_UP    = 4'd14;
    localparam logic [3:0] IO_SW_DOWN  = 4'd15;
    localparam logic [3:0] IO_LIGHTS   = 4'd15;

endpackage

// File: rtl/clk_tick_gen.sv
module clk_tick_gen #(
    parameter int DIV = 160
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    output logic tick_o
);
    localparam int W = (DIV > 1) ? $clog2(DIV) : 1;

    generate
        if (DIV > 1) begin : g_div
            typedef struct packed {
                logic [W-1:0] phase;
            } st_t;
            st_t st_d, st_q;

            always_comb begin
                st_d = st_q;
                tick_o = (st_q.phase == W'(DIV - 1));
                if (tick_o) st_d.phase = '0;
                else        st_d.phase = st_q.phase + 1'b1;
                if (clr_i)  st_d = '0;
            end

            always_ff @(posedge clk) begin
                if (!rst_n) st_q <= '0;
                else        st_q <= st_d;
            end

            // R3
            tick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
                tick_o |=> !tick_o);
        end else begin : g_every
            assign tick_o = 1'b1;
        end
    endgenerate
endmodule

// File: rtl/clk_interval.sv
module clk_interval #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_i,
    input  logic          start_i,
    input  logic          stop_i,
    input  logic          ack_i,
    input  logic          load_i,
    input  logic [CW-1:0] load_val_i,
    input  logic          clr_i,
    output logic          pend_o,
    output logic [CW-1:0] interval_o
);
    typedef struct packed {
        logic          run;
        logic          pend;
        logic [CW-1:0] count;
        logic [CW-1:0] interval;
    } st_t;

    st_t  st_d, st_q;
    logic ovf;

    always_comb begin
        st_d = st_q;
        ovf  = tick_i && st_q.run && (st_q.count == '1);
        if (tick_i && st_q.run) begin
            if (ovf) st_d.count = st_q.interval;
            else     st_d.count = st_q.count + 1'b1;
        end
        if (start_i) st_d.run = 1'b1;
        if (stop_i)  st_d.run = 1'b0;
        if (ack_i)   st_d.pend = 1'b0;
        if (ovf)     st_d.pend = 1'b1;
        if (load_i) begin
            st_d.interval = load_val_i;
            st_d.count    = load_val_i;
        end
        if (clr_i) st_d = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend_o     = st_q.pend;
    assign interval_o = st_q.interval;

    // R3
    pend_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pend_o && !clr_i && !tick_i) |=> !pend_o);
    // R5
    ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && !tick_i) |=> !pend_o);
    // R10
    hold_when_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.run && !start_i && !load_i && !clr_i) |=> $stable(st_q.count));
endmodule

// File: rtl/clk_watchdog.sv
module clk_watchdog #(
    parameter int LIMIT = 15625
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic arm_i,
    input  logic halt_i,
    input  logic clr_i,
    output logic expired_o
);
    localparam int WW = $clog2(LIMIT + 1);

    typedef struct packed {
        logic          active;
        logic          expired;
        logic [WW-1:0] elapsed;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (tick_i && st_q.active) begin
            if (st_q.elapsed == WW'(LIMIT - 1)) begin
                st_d.expired = 1'b1;
                st_d.active  = 1'b0;
            end else begin
                st_d.elapsed = st_q.elapsed + 1'b1;
            end
        end
        if (halt_i) st_d.active = 1'b0;
        if (arm_i) begin
            st_d.active  = 1'b1;
            st_d.expired = 1'b0;
            st_d.elapsed = '0;
        end
        if (clr_i) st_d = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign expired_o = st_q.expired;

    // R7
    expired_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (expired_o && !arm_i && !clr_i) |=> expired_o);
    // R7
    arm_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arm_i |=> !expired_o);
endmodule

// File: rtl/clk_pio_timer.sv
module clk_pio_timer
    import clk_pio_pkg::*;
#(
    parameter int CW        = 16,
    parameter int TICK_DIV  = 160,
    parameter int WDT_TICKS = 15625
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic [1:0]    cmd_class,
    input  logic [3:0]    cmd_func,
    input  logic [CW-1:0] cmd_wdata,
    output logic [CW-1:0] cmd_rdata,
    output logic          cmd_skip,
    input  logic [CW-1:0] panel_up,
    input  logic [CW-1:0] panel_down,
    output logic [CW-1:0] panel_lights,
    output logic          irq_req,
    output logic [CW-1:0] irq_vector,
    output logic          wdt_timeout
);
    typedef struct packed {
        logic          mask;
        logic [CW-1:0] vector;
        logic [CW-1:0] lights;
    } st_t;

    st_t       st_d, st_q;
    io_class_e cls;
    logic      is_ctrl, is_out;
    logic      c_run, c_ack, c_halt, c_arm, c_wstop, c_clr, c_load;
    logic      tick, pend;
    logic [CW-1:0] interval;

    always_comb begin
        cls     = io_class_e'(cmd_class);
        is_ctrl = cmd_valid && (cls == CLS_CTRL);
        is_out  = cmd_valid && (cls == CLS_OUT);
        c_run   = is_ctrl && (cmd_func == FN_RUN);
        c_halt  = is_ctrl && (cmd_func == FN_HALT);
        c_ack   = is_ctrl && (cmd_func == FN_ACK || c_run || c_halt);
        c_arm   = is_ctrl && (cmd_func == FN_WD_ARM);
        c_wstop = is_ctrl && (cmd_func == FN_WD_STOP);
        c_clr   = is_ctrl && (cmd_func == FN_CLEAR);
        c_load  = is_out  && (cmd_func == IO_INTERVAL);
    end

    clk_tick_gen #(.DIV(TICK_DIV)) i_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (c_clr),
        .tick_o (tick)
    );

    clk_interval #(.CW(CW)) i_interval (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick),
        .start_i    (c_run),
        .stop_i     (c_halt),
        .ack_i      (c_ack),
        .load_i     (c_load),
        .load_val_i (cmd_wdata),
        .clr_i      (c_clr),
        .pend_o     (pend),
        .interval_o (interval)
    );

    clk_watchdog #(.LIMIT(WDT_TICKS)) i_wdt (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick),
        .arm_i     (c_arm),
        .halt_i    (c_wstop),
        .clr_i     (c_clr),
        .expired_o (wdt_timeout)
    );

    always_comb begin
        st_d = st_q;
        if (is_ctrl && cmd_func == FN_MASK_ON)  st_d.mask   = 1'b1;
        if (is_ctrl && cmd_func == FN_MASK_OFF) st_d.mask   = 1'b0;
        if (is_out  && cmd_func == IO_VECTOR)   st_d.vector = cmd_wdata;
        if (is_out  && cmd_func == IO_LIGHTS)   st_d.lights = cmd_wdata;
        if (c_clr) st_d = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_req      = pend && st_q.mask;
    assign irq_vector   = st_q.vector;
    assign panel_lights = st_q.lights;

    always_comb begin
        cmd_rdata = '0;
        cmd_skip  = 1'b0;
        if (cmd_valid && cls == CLS_IN) begin
            case (cmd_func)
                IO_INTERVAL: cmd_rdata = interval;
                IO_SW_UP:    cmd_rdata = panel_up;
                IO_SW_DOWN:  cmd_rdata = panel_down;
                default:     cmd_rdata = '0;
            endcase
        end
        if (cmd_valid && cls == CLS_SKIP) begin
            case (cmd_func)
                SK_IRQ:    cmd_skip = irq_req;
                SK_NO_IRQ: cmd_skip = !irq_req;
                SK_WD_OUT: cmd_skip = wdt_timeout;
                default:   cmd_skip = 1'b0;
            endcase
        end
    end

    // R4
    mask_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_ctrl && cmd_func == FN_MASK_OFF) |=> !irq_req);
    // R6
    skip_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_class != 2'd1) |-> !cmd_skip);
    // R8
    vector_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (is_out && cmd_func == IO_VECTOR) |=> irq_vector == $past(cmd_wdata));
    // R9
    clear_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        c_clr |=> (!irq_req && !wdt_timeout && panel_lights == '0 && irq_vector == '0));
endmodule

// File: tb/test_clk_pio_timer.sv
module test_clk_pio_timer;
    localparam int DIV = 4;
    localparam int WDT = 10;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        cmd_valid = 0;
    logic [1:0]  cmd_class = 0;
    logic [3:0]  cmd_func = 0;
    logic [15:0] cmd_wdata = 0;
    logic [15:0] cmd_rdata;
    logic        cmd_skip;
    logic [15:0] panel_up = 16'h1234;
    logic [15:0] panel_down = 16'h0081;
    logic [15:0] panel_lights;
    logic        irq_req;
    logic [15:0] irq_vector;
    logic        wdt_timeout;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit cmp_en = 0;

    always #10 clk = ~clk;

    clk_pio_timer #(.CW(16), .TICK_DIV(DIV), .WDT_TICKS(WDT)) i_clk_pio_timer (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_class(cmd_class),
        .cmd_func(cmd_func), .cmd_wdata(cmd_wdata), .cmd_rdata(cmd_rdata),
        .cmd_skip(cmd_skip), .panel_up(panel_up), .panel_down(panel_down),
        .panel_lights(panel_lights), .irq_req(irq_req), .irq_vector(irq_vector),
        .wdt_timeout(wdt_timeout)
    );

    // behavioural reference
    int          m_phase;
    logic [15:0] m_cnt, m_int, m_vec, m_lights;
    bit          m_run, m_pend, m_mask, m_wen, m_wexp;
    int          m_wcnt;

    task automatic m_reset();
        m_phase = 0; m_cnt = 0; m_int = 0; m_vec = 0; m_lights = 0;
        m_run = 0; m_pend = 0; m_mask = 0; m_wen = 0; m_wexp = 0; m_wcnt = 0;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (!rst_n) m_reset();
        else begin
            bit tk, ov, c, o;
            tk = (m_phase == DIV - 1);
            m_phase = tk ? 0 : m_phase + 1;
            ov = tk && m_run && (m_cnt == 16'hFFFF);
            if (tk && m_run) m_cnt = ov ? m_int : m_cnt + 16'd1;
            if (tk && m_wen) begin
                if (m_wcnt == WDT - 1) begin m_wexp = 1; m_wen = 0; end
                else m_wcnt++;
            end
            c = cmd_valid && cmd_class == 2'd0;
            o = cmd_valid && cmd_class == 2'd3;
            if (c) begin
                case (cmd_func)
                    4'd0:  begin m_run = 1; m_pend = 0; end
                    4'd1:  m_pend = 0;
                    4'd2:  begin m_run = 0; m_pend = 0; end
                    4'd6:  begin m_wen = 1; m_wexp = 0; m_wcnt = 0; end
                    4'd7:  m_wen = 0;
                    4'd13: m_mask = 1;
                    4'd14: m_mask = 0;
                    default: ;
                endcase
            end
            if (ov) m_pend = 1;
            if (o && cmd_func == 4'd2) begin m_int = cmd_wdata; m_cnt = cmd_wdata; end
            if (o && cmd_func == 4'd11) m_vec = cmd_wdata;
            if (o && cmd_func == 4'd15) m_lights = cmd_wdata;
            if (c && cmd_func == 4'd15) m_reset();
        end
    end

    function automatic logic [15:0] exp_rdata();
        if (!(cmd_valid && cmd_class == 2'd2)) return 16'h0;
        case (cmd_func)
            4'd2:  return m_int;
            4'd14: return panel_up;
            4'd15: return panel_down;
            default: return 16'h0;
        endcase
    endfunction

    function automatic bit exp_skip();
        if (!(cmd_valid && cmd_class == 2'd1)) return 0;
        case (cmd_func)
            4'd0: return m_pend && m_mask;
            4'd2: return !(m_pend && m_mask);
            4'd5: return m_wexp;
            default: return 0;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h time=%0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        #2;
        if (cmp_en) begin
            chk("R4 irq_req", {15'd0, irq_req}, {15'd0, m_pend && m_mask});
            chk("R8 irq_vector", irq_vector, m_vec);
            chk("R8 panel_lights", panel_lights, m_lights);
            chk("R7 wdt_timeout", {15'd0, wdt_timeout}, {15'd0, m_wexp});
            chk("R2 cmd_rdata", cmd_rdata, exp_rdata());
            chk("R6 cmd_skip", {15'd0, cmd_skip}, {15'd0, exp_skip()});
        end
    end

    task automatic cmd(input logic [1:0] c, input logic [3:0] f, input logic [15:0] d);
        @(negedge clk);
        cmd_valid = 1; cmd_class = c; cmd_func = f; cmd_wdata = d;
        #5;
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        cmd_valid = 0; cmd_class = 0; cmd_func = 0; cmd_wdata = 0;
        repeat (n) @(negedge clk);
        #5;
    endtask

    bit done = 0;
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired, actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        cmp_en = 1;
        #5;
        // R1 reset state
        chk("R1 irq", {15'd0, irq_req}, 16'd0);
        chk("R1 lights", panel_lights, 16'd0);
        chk("R1 vector", irq_vector, 16'd0);
        chk("R1 wdt", {15'd0, wdt_timeout}, 16'd0);
        cmd(2'd2, 4'd2, 0);
        chk("R1 interval", cmd_rdata, 16'd0);

        // R8 vector, lights, switches
        cmd(2'd3, 4'd11, 16'h0140);
        cmd(2'd3, 4'd15, 16'hA5A5);
        cmd(2'd2, 4'd14, 0);
        chk("R8 sw up", cmd_rdata, 16'h1234);
        cmd(2'd2, 4'd15, 0);
        chk("R8 sw down", cmd_rdata, 16'h0081);
        cmd(2'd2, 4'd5, 0);
        chk("R8 other input", cmd_rdata, 16'h0);
        idle(1);
        chk("R8 vector", irq_vector, 16'h0140);
        chk("R8 lights", panel_lights, 16'hA5A5);

        // R2 load and readback
        cmd(2'd3, 4'd2, 16'hFFFD);
        cmd(2'd2, 4'd2, 0);
        chk("R2 readback", cmd_rdata, 16'hFFFD);

        // R3 overflow with mask on
        cmd(2'd0, 4'd13, 0);
        cmd(2'd0, 4'd0, 0);
        idle(3 * DIV + DIV);
        chk("R3 overflow irq", {15'd0, irq_req}, 16'd1);
        cmd(2'd1, 4'd0, 0);
        chk("R6 skip irq", {15'd0, cmd_skip}, 16'd1);
        cmd(2'd1, 4'd2, 0);
        chk("R6 skip no irq", {15'd0, cmd_skip}, 16'd0);
        cmd(2'd3, 4'd0, 0);
        chk("R6 no skip on output", {15'd0, cmd_skip}, 16'd0);

        // R5 acknowledge, then reload gives another event
        cmd(2'd0, 4'd1, 0);
        idle(0);
        chk("R5 ack", {15'd0, irq_req}, {15'd0, m_pend && m_mask});
        idle(3 * DIV + DIV);
        chk("R3 reload", {15'd0, irq_req}, 16'd1);

        // R4 mask off hides the pending flag
        cmd(2'd0, 4'd14, 0);
        idle(0);
        chk("R4 masked", {15'd0, irq_req}, 16'd0);
        cmd(2'd0, 4'd13, 0);

        // R10 stopped clock holds the count
        cmd(2'd0, 4'd2, 0);
        idle(10 * DIV);
        chk("R10 stopped", {15'd0, irq_req}, 16'd0);
        cmd(2'd0, 4'd0, 0);
        idle(3 * DIV + DIV);
        chk("R10 resumed", {15'd0, irq_req}, 16'd1);
        cmd(2'd0, 4'd2, 0);

        // R7 watchdog
        cmd(2'd0, 4'd6, 0);
        idle(WDT * DIV - 2 * DIV);
        chk("R7 not yet", {15'd0, wdt_timeout}, 16'd0);
        idle(3 * DIV);
        chk("R7 expired", {15'd0, wdt_timeout}, 16'd1);
        cmd(2'd1, 4'd5, 0);
        chk("R6 skip wdt", {15'd0, cmd_skip}, 16'd1);
        cmd(2'd0, 4'd7, 0);
        idle(2);
        chk("R7 sticky", {15'd0, wdt_timeout}, 16'd1);
        cmd(2'd0, 4'd6, 0);
        idle(0);
        chk("R7 rearm", {15'd0, wdt_timeout}, 16'd0);
        cmd(2'd0, 4'd7, 0);

        // R9 master clear
        cmd(2'd0, 4'd0, 0);
        cmd(2'd0, 4'd15, 0);
        cmd(2'd2, 4'd2, 0);
        chk("R9 interval", cmd_rdata, 16'd0);
        chk("R9 lights", panel_lights, 16'd0);
        chk("R9 vector", irq_vector, 16'd0);

        // mixed traffic against the model
        for (int i = 0; i < 4000; i++) begin
            int r;
            r = $urandom_range(0, 39);
            panel_up = 16'($urandom);
            if (r < 8)       idle(0);
            else if (r < 12) cmd(2'd0, 4'd1, 0);
            else if (r < 14) cmd(2'd0, 4'd0, 0);
            else if (r < 15) cmd(2'd0, 4'd2, 0);
            else if (r < 17) cmd(2'd0, 4'(13 + (r & 1)), 0);
            else if (r < 19) cmd(2'd0, 4'(6 + (r & 1)), 0);
            else if (r < 21) cmd(2'd3, 4'd2, 16'hFFFF - 16'($urandom_range(0, 5)));
            else if (r < 23) cmd(2'd3, 4'(11 + 4 * (r & 1)), 16'($urandom));
            else if (r < 30) cmd(2'd1, 4'($urandom_range(0, 15)), 0);
            else if (r < 37) cmd(2'd2, 4'($urandom_range(0, 15)), 0);
            else if (r < 38) cmd(2'd0, 4'd15, 0);
            else             cmd(2'd0, 4'($urandom_range(3, 12)), 0);
        end
        idle(2);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule